// File: doc/BRIEF.md
# Three-Multiplier Complex Multiplier

This block multiplies two complex operands, (a + jb) and (c + jd), and returns the complex product at full precision. Only three real multiplications are used, not the usual four. One shared product, (a − b)·d, is formed once and added into both results. The real part is then (c − d)·a plus the shared product, and the imaginary part is (c + d)·b plus the shared product.

The datapath has three register stages: pre-add, multiply and post-add. One operand pair can enter on every clock cycle, marked by an input valid strobe. A matching output valid strobe comes out exactly three cycles later.

All operands are signed two's complement, W bits each. Both outputs are signed, 2W+2 bits wide. This is wide enough for every input combination, so the results never wrap.

Top module: `cmul3_top`

## Requirements
- R1: When `out_valid` is high, `out_re` equals a·c − b·d for the operand set that was accepted three cycles earlier. All values are interpreted as signed two's complement.
- R2: When `out_valid` is high, `out_im` equals a·d + b·c for the operand set that was accepted three cycles earlier.
- R3: The outputs are 2W+2 bits wide and exact for every input combination, including operands at the most negative value (−2^(W−1)).
- R4: `out_valid` is high in a cycle exactly when `in_valid` was high three rising clock edges earlier.
- R5: A new operand set can be accepted on every cycle, with no bubbles. Back-to-back inputs produce back-to-back results in the same order.
- R6: While `out_valid` is low, `out_re` and `out_im` keep the values of the most recent valid result.
- R7: While `rst_n` is low, `out_valid`, `out_re` and `out_im` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand set on the inputs is valid this cycle |
| in_a | input | W | Real part of the first operand, signed |
| in_b | input | W | Imaginary part of the first operand, signed |
| in_c | input | W | Real part of the second operand, signed |
| in_d | input | W | Imaginary part of the second operand, signed |
| out_valid | output | 1 | Result on the outputs is valid this cycle |
| out_re | output | 2W+2 | Real part of the product, signed |
| out_im | output | 2W+2 | Imaginary part of the product, signed |

## Verification
The bench builds the block with W = 4. This makes all 65,536 combinations of the four operands small enough to stream through one after another, so every extreme corner is reached, including all four operands at −8. Idle cycles are inserted at regular points in the stream. These test the strobe timing and the hold behaviour between results. Expected values come from the direct four-product formula, which is independent of the shared-term decomposition.

// File: rtl/cmul3_pkg.sv
package cmul3_pkg;

    // Pipeline depth: pre-add, multiply, post-add.
    localparam int unsigned CMUL_LAT = 3;

    // Width of a full-precision complex product component.
    function automatic int prod_width(input int w);
        return 2 * w + 2;
    endfunction

endpackage

// File: rtl/cmul3_preadd.sv
module cmul3_preadd #(
    parameter int W  = 16,
    parameter int PW = W + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [W-1:0]  in_a,
    input  logic signed [W-1:0]  in_b,
    input  logic signed [W-1:0]  in_c,
    input  logic signed [W-1:0]  in_d,
    output logic                 v_o,
    output logic signed [W-1:0]  a_o,
    output logic signed [W-1:0]  b_o,
    output logic signed [W-1:0]  d_o,
    output logic signed [PW-1:0] cmd_o,
    output logic signed [PW-1:0] cpd_o,
    output logic signed [PW-1:0] amb_o
);

    typedef struct packed {
        logic                 v;
        logic signed [W-1:0]  a;
        logic signed [W-1:0]  b;
        logic signed [W-1:0]  d;
        logic signed [PW-1:0] cmd;
        logic signed [PW-1:0] cpd;
        logic signed [PW-1:0] amb;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        st_d.v = in_valid;
        if (in_valid) begin
            st_d.a   = in_a;
            st_d.b   = in_b;
            st_d.d   = in_d;
            st_d.cmd = PW'(in_c) - PW'(in_d);
            st_d.cpd = PW'(in_c) + PW'(in_d);
            st_d.amb = PW'(in_a) - PW'(in_b);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign v_o   = st_q.v;
    assign a_o   = st_q.a;
    assign b_o   = st_q.b;
    assign d_o   = st_q.d;
    assign cmd_o = st_q.cmd;
    assign cpd_o = st_q.cpd;
    assign amb_o = st_q.amb;

    // The sum and difference terms must differ by exactly twice the stored d.
    AST_PREADD_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.v |-> (PW'(st_q.cpd - st_q.cmd) == PW'({st_q.d, 1'b0}))); // R1

endmodule

// File: rtl/cmul3_mult.sv
module cmul3_mult #(
    parameter int W  = 16,
    parameter int PW = W + 1,
    parameter int MW = PW + W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 v_i,
    input  logic signed [W-1:0]  a_i,
    input  logic signed [W-1:0]  b_i,
    input  logic signed [W-1:0]  d_i,
    input  logic signed [PW-1:0] cmd_i,
    input  logic signed [PW-1:0] cpd_i,
    input  logic signed [PW-1:0] amb_i,
    output logic                 v_o,
    output logic signed [MW-1:0] pre_o,
    output logic signed [MW-1:0] pim_o,
    output logic signed [MW-1:0] shr_o
);

    typedef struct packed {
        logic                 v;
        logic signed [MW-1:0] pre;
        logic signed [MW-1:0] pim;
        logic signed [MW-1:0] shr;
    } st_t;

    st_t st_d, st_q;

    // All three products sit behind the same register count, so the shared
    // term meets its partners in the post-add without extra delay.
    always_comb begin
        st_d   = st_q;
        st_d.v = v_i;
        if (v_i) begin
            st_d.pre = MW'(cmd_i) * MW'(a_i);
            st_d.pim = MW'(cpd_i) * MW'(b_i);
            st_d.shr = MW'(amb_i) * MW'(d_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign v_o   = st_q.v;
    assign pre_o = st_q.pre;
    assign pim_o = st_q.pim;
    assign shr_o = st_q.shr;

    // Strobe advances one stage per edge.
    AST_MULT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        v_i |=> st_q.v); // R4

endmodule

// File: rtl/cmul3_postadd.sv
module cmul3_postadd #(
    parameter int MW = 33,
    parameter int OW = MW + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 v_i,
    input  logic signed [MW-1:0] pre_i,
    input  logic signed [MW-1:0] pim_i,
    input  logic signed [MW-1:0] shr_i,
    output logic                 v_o,
    output logic signed [OW-1:0] re_o,
    output logic signed [OW-1:0] im_o
);

    typedef struct packed {
        logic                 v;
        logic signed [OW-1:0] re;
        logic signed [OW-1:0] im;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        st_d.v = v_i;
        if (v_i) begin
            st_d.re = OW'(pre_i) + OW'(shr_i);
            st_d.im = OW'(pim_i) + OW'(shr_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign v_o  = st_q.v;
    assign re_o = st_q.re;
    assign im_o = st_q.im;

    // Results only move when a new valid result is registered.
    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.v |-> ($stable(st_q.re) && $stable(st_q.im))); // R6

endmodule

// File: rtl/cmul3_top.sv
module cmul3_top #(
    parameter  int W  = 16,
    localparam int OW = 2 * W + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [W-1:0]  in_a,
    input  logic signed [W-1:0]  in_b,
    input  logic signed [W-1:0]  in_c,
    input  logic signed [W-1:0]  in_d,
    output logic                 out_valid,
    output logic signed [OW-1:0] out_re,
    output logic signed [OW-1:0] out_im
);

    localparam int PW = W + 1;
    localparam int MW = PW + W;
    localparam int RW = cmul3_pkg::prod_width(W);

    logic                 s1_v;
    logic signed [W-1:0]  s1_a, s1_b, s1_d;
    logic signed [PW-1:0] s1_cmd, s1_cpd, s1_amb;
    logic                 s2_v;
    logic signed [MW-1:0] s2_pre, s2_pim, s2_shr;
    logic signed [RW-1:0] s3_re, s3_im;

    cmul3_preadd #(.W(W), .PW(PW)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_valid(in_valid),
        .in_a    (in_a),
        .in_b    (in_b),
        .in_c    (in_c),
        .in_d    (in_d),
        .v_o     (s1_v),
        .a_o     (s1_a),
        .b_o     (s1_b),
        .d_o     (s1_d),
        .cmd_o   (s1_cmd),
        .cpd_o   (s1_cpd),
        .amb_o   (s1_amb)
    );

    cmul3_mult #(.W(W), .PW(PW), .MW(MW)) u_mul (
        .clk   (clk),
        .rst_n (rst_n),
        .v_i   (s1_v),
        .a_i   (s1_a),
        .b_i   (s1_b),
        .d_i   (s1_d),
        .cmd_i (s1_cmd),
        .cpd_i (s1_cpd),
        .amb_i (s1_amb),
        .v_o   (s2_v),
        .pre_o (s2_pre),
        .pim_o (s2_pim),
        .shr_o (s2_shr)
    );

    cmul3_postadd #(.MW(MW), .OW(RW)) u_post (
        .clk   (clk),
        .rst_n (rst_n),
        .v_i   (s2_v),
        .pre_i (s2_pre),
        .pim_i (s2_pim),
        .shr_i (s2_shr),
        .v_o   (out_valid),
        .re_o  (s3_re),
        .im_o  (s3_im)
    );

    assign out_re = OW'(s3_re);
    assign out_im = OW'(s3_im);

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##3 out_valid); // R4

    AST_ZERO_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_a == '0 && in_b == '0) |-> ##3
        (out_valid && out_re == '0 && out_im == '0)); // R1

endmodule

// File: tb/cmul3_top_tb.sv
`timescale 1ns/1ps
module cmul3_top_tb;

    localparam int W  = 4;
    localparam int OW = 2 * W + 2;
    localparam int LO = -(1 <<< (W - 1));
    localparam int HI = (1 <<< (W - 1)) - 1;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic signed [W-1:0]  in_a = '0, in_b = '0, in_c = '0, in_d = '0;
    logic                 out_valid;
    logic signed [OW-1:0] out_re, out_im;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Expected pipeline mirrors the required three-edge latency.
    bit exp_v   [3];
    int exp_re  [3];
    int exp_im  [3];
    int last_re = 0;
    int last_im = 0;
    int cur_re  = 0;
    int cur_im  = 0;

    always #2.5 clk = ~clk;

    cmul3_top #(.W(W)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_a     (in_a),
        .in_b     (in_b),
        .in_c     (in_c),
        .in_d     (in_d),
        .out_valid(out_valid),
        .out_re   (out_re),
        .out_im   (out_im)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) begin
                exp_v[i] <= 1'b0; exp_re[i] <= 0; exp_im[i] <= 0;
            end
        end else begin
            exp_v[0]  <= in_valid;
            exp_re[0] <= int'(in_a) * int'(in_c) - int'(in_b) * int'(in_d);
            exp_im[0] <= int'(in_a) * int'(in_d) + int'(in_b) * int'(in_c);
            for (int i = 1; i < 3; i++) begin
                exp_v[i] <= exp_v[i-1]; exp_re[i] <= exp_re[i-1]; exp_im[i] <= exp_im[i-1];
            end
        end
    end

    // Monitor samples 1 ns after each rising edge.
    always @(posedge clk) begin
        #1;
        if (!rst_n) begin
            check(out_valid == 1'b0, "R7 valid", int'(out_valid), 0);
            check(out_re == '0 && out_im == '0, "R7 data", int'(out_re), 0);
        end else if (!done) begin
            check(out_valid == exp_v[2], "R4 strobe", int'(out_valid), int'(exp_v[2]));
            if (exp_v[2]) begin
                cur_re = int'(out_re);
                cur_im = int'(out_im);
                check(cur_re == exp_re[2], "R1/R3/R5 real", cur_re, exp_re[2]);
                check(cur_im == exp_im[2], "R2/R3/R5 imag", cur_im, exp_im[2]);
                last_re = exp_re[2];
                last_im = exp_im[2];
            end else begin
                check(int'(out_re) == last_re, "R6 hold real", int'(out_re), last_re);
                check(int'(out_im) == last_im, "R6 hold imag", int'(out_im), last_im);
            end
        end
    end

    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // Exhaustive sweep, back-to-back, with an idle gap every 97 sets (R5, R6).
        for (int a = LO; a <= HI; a++)
            for (int b = LO; b <= HI; b++)
                for (int c = LO; c <= HI; c++)
                    for (int d = LO; d <= HI; d++) begin
                        @(negedge clk);
                        in_valid = 1'b1;
                        in_a = W'(a); in_b = W'(b); in_c = W'(c); in_d = W'(d);
                        n++;
                        if (n % 97 == 0) begin
                            @(negedge clk);
                            in_valid = 1'b0;
                            in_a = W'(HI); in_b = W'(LO); in_c = W'(HI); in_d = W'(LO);
                            @(negedge clk);
                            in_valid = 1'b0;
                        end
                    end
        @(negedge clk);
        in_valid = 1'b0;
        repeat (6) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule